// File: doc/BRIEF.md
# Iterative SM4 Block Cipher Core

This block encrypts or decrypts one 128-bit block under a 128-bit key using the SM4 cipher. It uses a single iterative datapath. One substitution stage serves both the key expansion and the data rounds. That stage is an XOR of three state words with a constant or round key, feeding four byte S-boxes. A select signal decides on each cycle which of the two paths drives it. Two separate linear layers follow the shared stage: one for the round path and one for the key path. The round constants are not read from a table; they advance by arithmetic during each data round.

A caller raises `work_i` and holds it high for the whole operation. In the four clock cycles after the start, the data block and the key arrive one 32-bit word per cycle, most significant word first. Encryption interleaves 32 key steps with 32 data rounds and keeps every round key it produces. Decryption takes no key. It replays the round keys left by the most recent completed encryption, newest first, and refuses to start when no complete key set is held. The result stays on `result_o` until the next operation starts. Dropping `work_i` at any time returns the core to idle.

Top module: `sm4_iter_core`

## Requirements
- R1: After reset, `done_o` and `key_err_o` are low and `result_o` is all zeros.
- R2: An operation starts on the first clock edge at which `work_i` is high in idle. The four edges that follow take data word 0..3 from `blk_word_i` and key word 0..3 from `key_word_i`. Word 0 is bits 127:96 of the block or key. Each key word is XORed with its system constant (A3B1BAC6, 56AA3350, 677D9197, B27022DC for words 0..3) before use.
- R3: Encryption of the block 0123456789ABCDEFFEDCBA9876543210 under the same value as key yields 681EDF34D206965E86B3E94F536E4246. `done_o` rises 64 clock edges after the edge that takes the last input word.
- R4: Decryption of a ciphertext produced by the most recent completed encryption returns its plaintext. `done_o` rises 32 clock edges after the edge that takes the last input word.
- R5: During decryption `key_word_i` has no effect on the result.
- R6: `done_o` is high for exactly one cycle per operation. `result_o` keeps its value while `work_i` stays high afterwards, and also after `work_i` falls, until the next start.
- R7: A decrypt request (`decrypt_i` high when work starts) made while no complete key set is stored sets `key_err_o` from the next edge for as long as `work_i` stays high. It starts nothing and changes neither `result_o` nor `done_o`.
- R8: `work_i` low in any non-idle state returns the core to idle on the next edge with no `done_o` pulse. An encryption aborted this way leaves no usable key set, so a following decrypt request is rejected as in R7.
- R9: After two encryptions under different keys, a decryption uses the round keys of the second one.
- R10: The round constant used by key step i has byte j (j = 0 in bits 31:24) equal to (28·i + 7·j) mod 256. Successive bytes of one constant always differ by 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| work_i | input | 1 | Held high to run an operation; low forces idle |
| decrypt_i | input | 1 | Mode sampled at start: 1 decrypt, 0 encrypt |
| blk_word_i | input | 32 | Serial data word during loading |
| key_word_i | input | 32 | Serial key word during loading (encryption only) |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| key_err_o | output | 1 | Decrypt request rejected: no stored key set |
| result_o | output | 128 | Output block, first output word in bits 127:96 |

## Verification
Every result here has a fixed distance from its stimulus. The rejection flag is due one edge after the start edge. The loading phase ends four edges after the start. The completion pulse follows 64 edges later for encryption and 32 for decryption. The pulse falls on the next edge, and an abort takes effect one edge after `work_i` drops. The bench drives inputs on falling edges and counts rising edges from the last loading edge. It samples at the falling edge where each result is due and compares the count against the expected latency. This catches an early or late completion even when the data is correct.

// File: rtl/sm4_core_pkg.sv
package sm4_core_pkg;

    localparam int WORD_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int NWORD   = 4;
    localparam logic [7:0] GF_POLY_LO = 8'hF5;   // x^8 = x^7+x^6+x^5+x^4+x^2+1
    localparam logic [7:0] AFF_CONST  = 8'hD3;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LOAD = 3'd1,
        ST_KEY  = 3'd2,
        ST_RND  = 3'd3,
        ST_HOLD = 3'd4
    } seq_e;

    // key whitening constants, indexed by the order of arrival
    function automatic logic [WORD_W-1:0] fk_word(input logic [1:0] idx);
        logic [WORD_W-1:0] r;
        case (idx)
            2'd0:    r = 32'hA3B1BAC6;
            2'd1:    r = 32'h56AA3350;
            2'd2:    r = 32'h677D9197;
            default: r = 32'hB27022DC;
        endcase
        return r;
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] aa;
        acc = '0;
        aa  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ aa;
            aa = {aa[6:0], 1'b0} ^ (aa[7] ? GF_POLY_LO : 8'h00);
        end
        return acc;
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] v, input int unsigned k);
        return (v << k) | (v >> (8 - k));
    endfunction

    // circulant bit matrix used before and after the field inversion
    function automatic logic [7:0] affine_mat(input logic [7:0] v);
        return v ^ rotl8(v, 1) ^ rotl8(v, 3) ^ rotl8(v, 6) ^ rotl8(v, 7);
    endfunction

    function automatic logic [WORD_W-1:0] rotl32(input logic [WORD_W-1:0] v, input int unsigned k);
        return (v << k) | (v >> (WORD_W - k));
    endfunction

    function automatic logic [WORD_W-1:0] lin_data(input logic [WORD_W-1:0] b);
        return b ^ rotl32(b, 2) ^ rotl32(b, 10) ^ rotl32(b, 18) ^ rotl32(b, 24);
    endfunction

    function automatic logic [WORD_W-1:0] lin_key(input logic [WORD_W-1:0] b);
        return b ^ rotl32(b, 13) ^ rotl32(b, 23);
    endfunction

endpackage

// File: rtl/sm4_sbox.sv
module sm4_sbox
    import sm4_core_pkg::*;
(
    input  logic [7:0] din,
    output logic [7:0] dout
);
    logic [7:0] pre;
    logic [7:0] p2, p3, p6, p7, p14, p15, p30, p31, p62, p63, p126, p127, inv;

    always_comb begin
        pre  = affine_mat(din) ^ AFF_CONST;
        // inversion as pre^254 by an addition chain; zero maps to zero
        p2   = gf_mul(pre, pre);
        p3   = gf_mul(p2, pre);
        p6   = gf_mul(p3, p3);
        p7   = gf_mul(p6, pre);
        p14  = gf_mul(p7, p7);
        p15  = gf_mul(p14, pre);
        p30  = gf_mul(p15, p15);
        p31  = gf_mul(p30, pre);
        p62  = gf_mul(p31, p31);
        p63  = gf_mul(p62, pre);
        p126 = gf_mul(p63, p63);
        p127 = gf_mul(p126, pre);
        inv  = gf_mul(p127, p127);
        dout = affine_mat(inv) ^ AFF_CONST;
    end

    // inversion property: a nonzero operand times its inverse is one
    always_comb begin
        inv_unit_chk: assert (pre == 8'h00 || gf_mul(pre, inv) == 8'h01);
    end
endmodule

// File: rtl/sm4_tbox.sv
module sm4_tbox
    import sm4_core_pkg::*;
#(
    parameter int NBYTES = 4
) (
    input  logic [NBYTES*8-1:0] din,
    output logic [NBYTES*8-1:0] dout
);
    for (genvar g = 0; g < NBYTES; g++) begin : g_sb
        sm4_sbox u_sb (
            .din  (din [g*8 +: 8]),
            .dout (dout[g*8 +: 8])
        );
    end
endmodule

// File: rtl/sm4_ckgen.sv
module sm4_ckgen #(
    parameter int NBYTES = 4,
    parameter int STEP   = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                init_i,
    input  logic                adv_i,
    output logic [NBYTES*8-1:0] ck_o
);
    localparam int W   = NBYTES * 8;
    localparam logic [7:0] INC = 8'((NBYTES * STEP) % 256);

    logic [W-1:0] ck_d, ck_q, ck_init;

    for (genvar j = 0; j < NBYTES; j++) begin : g_byte
        // byte 0 sits in the most significant position
        assign ck_init[W-1-8*j -: 8] = 8'((j * STEP) % 256);
        always_comb begin
            if (init_i)     ck_d[W-1-8*j -: 8] = ck_init[W-1-8*j -: 8];
            else if (adv_i) ck_d[W-1-8*j -: 8] = ck_q[W-1-8*j -: 8] + INC;
            else            ck_d[W-1-8*j -: 8] = ck_q[W-1-8*j -: 8];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ck_q <= ck_init;
        else        ck_q <= ck_d;
    end

    assign ck_o = ck_q;

    // R10
    ck_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ck_q[W-9 -: 8] - ck_q[W-1 -: 8]) == 8'(STEP));
    // R10
    ck_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (ck_q[W-1 -: 8] == 8'h00));
endmodule

// File: rtl/sm4_rkfile.sv
module sm4_rkfile #(
    parameter int DEPTH = 32,
    parameter int W     = 32
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [W-1:0]             wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [W-1:0]             rdata
);
    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/sm4_iter_core.sv
module sm4_iter_core
    import sm4_core_pkg::*;
#(
    parameter int NRND = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         work_i,
    input  logic         decrypt_i,
    input  logic [31:0]  blk_word_i,
    input  logic [31:0]  key_word_i,
    output logic         done_o,
    output logic         key_err_o,
    output logic [127:0] result_o
);
    localparam int RND_W = $clog2(NRND);
    localparam int WC_W  = $clog2(NWORD);
    localparam logic [RND_W-1:0] LAST_RND = RND_W'(NRND - 1);
    localparam logic [WC_W-1:0]  LAST_WRD = WC_W'(NWORD - 1);

    typedef struct packed {
        seq_e                           st;
        logic [WC_W-1:0]                wcnt;
        logic [RND_W-1:0]               rnd;
        logic                           dec;
        logic                           keys_ok;
        logic                           done;
        logic                           err;
        logic [NWORD-1:0][WORD_W-1:0]   x;
        logic [NWORD-1:0][WORD_W-1:0]   k;
    } core_s;

    core_s q, n;

    logic              sel_rnd;
    logic              ck_init, ck_adv, rk_we;
    logic [WORD_W-1:0] ck_cur, rk_rd, rk_use, tb_in, tb_out, key_new, rnd_new;
    logic [RND_W-1:0]  rk_raddr;

    // shared substitution stage input select
    assign sel_rnd  = (q.st == ST_RND);
    assign rk_raddr = LAST_RND - q.rnd;
    assign rk_use   = q.dec ? rk_rd : q.k[3];
    assign tb_in    = sel_rnd ? (q.x[1] ^ q.x[2] ^ q.x[3] ^ rk_use)
                              : (q.k[1] ^ q.k[2] ^ q.k[3] ^ ck_cur);
    assign key_new  = q.k[0] ^ lin_key(tb_out);
    assign rnd_new  = q.x[0] ^ lin_data(tb_out);

    sm4_tbox #(.NBYTES(WORD_W / BYTE_W)) u_tbox (
        .din  (tb_in),
        .dout (tb_out)
    );

    sm4_ckgen #(.NBYTES(WORD_W / BYTE_W), .STEP(7)) u_ckgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .init_i (ck_init),
        .adv_i  (ck_adv),
        .ck_o   (ck_cur)
    );

    sm4_rkfile #(.DEPTH(NRND), .W(WORD_W)) u_rkf (
        .clk   (clk),
        .we    (rk_we),
        .waddr (q.rnd),
        .wdata (key_new),
        .raddr (rk_raddr),
        .rdata (rk_rd)
    );

    always_comb begin
        n       = q;
        n.done  = 1'b0;
        n.err   = 1'b0;
        ck_init = 1'b0;
        ck_adv  = 1'b0;
        rk_we   = 1'b0;
        if (q.st != ST_IDLE && !work_i) begin
            n.st = ST_IDLE;
        end else begin
            case (q.st)
                ST_IDLE: begin
                    if (work_i) begin
                        if (decrypt_i && !q.keys_ok) begin
                            n.err = 1'b1;
                        end else begin
                            n.st    = ST_LOAD;
                            n.wcnt  = '0;
                            n.rnd   = '0;
                            n.dec   = decrypt_i;
                            ck_init = 1'b1;
                            if (!decrypt_i) n.keys_ok = 1'b0;
                        end
                    end
                end
                ST_LOAD: begin
                    n.x[q.wcnt] = blk_word_i;
                    if (!q.dec) n.k[q.wcnt] = key_word_i ^ fk_word(q.wcnt);
                    n.wcnt = q.wcnt + 1'b1;
                    if (q.wcnt == LAST_WRD) n.st = q.dec ? ST_RND : ST_KEY;
                end
                ST_KEY: begin
                    n.k   = {key_new, q.k[3], q.k[2], q.k[1]};
                    rk_we = 1'b1;
                    n.st  = ST_RND;
                end
                ST_RND: begin
                    n.x    = {rnd_new, q.x[3], q.x[2], q.x[1]};
                    ck_adv = 1'b1;
                    if (q.rnd == LAST_RND) begin
                        n.st   = ST_HOLD;
                        n.done = 1'b1;
                        if (!q.dec) n.keys_ok = 1'b1;
                    end else begin
                        n.rnd = q.rnd + 1'b1;
                        n.st  = q.dec ? ST_RND : ST_KEY;
                    end
                end
                ST_HOLD: begin
                    n.st = ST_HOLD;
                end
                default: n.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, wcnt: '0, rnd: '0, dec: 1'b0, keys_ok: 1'b0,
                   done: 1'b0, err: 1'b0, x: '0, k: '0};
        end else begin
            q <= n;
        end
    end

    assign done_o    = q.done;
    assign key_err_o = q.err;
    assign result_o  = q.x;

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);
    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_HOLD && $past(q.st == ST_HOLD)) |-> $stable(q.x));
    // R7
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.err |-> (q.st == ST_IDLE && !q.done));
    // R8
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!work_i && q.st != ST_IDLE) |=> (q.st == ST_IDLE && !q.done));
    // R3
    key_then_round_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_KEY) |=> (q.st == ST_RND || q.st == ST_IDLE));
    // R8
    keys_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_KEY) |-> !q.keys_ok);
endmodule

// File: tb/sm4_iter_core_tb.sv
module sm4_iter_core_tb;
    localparam int NRND = 32;
    localparam logic [127:0] KV_KEY = 128'h0123456789ABCDEFFEDCBA9876543210;
    localparam logic [127:0] KV_PT  = 128'h0123456789ABCDEFFEDCBA9876543210;
    localparam logic [127:0] KV_CT  = 128'h681EDF34D206965E86B3E94F536E4246;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         work = 1'b0;
    logic         decrypt = 1'b0;
    logic [31:0]  blk_w = '0;
    logic [31:0]  key_w = '0;
    logic         done, kerr;
    logic [127:0] result;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    sm4_iter_core #(.NRND(NRND)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .work_i     (work),
        .decrypt_i  (decrypt),
        .blk_word_i (blk_w),
        .key_word_i (key_w),
        .done_o     (done),
        .key_err_o  (kerr),
        .result_o   (result)
    );

    function automatic int exp_lat(input bit dec);
        return dec ? NRND : 2 * NRND;
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(input bit dec, input logic [127:0] blk, input logic [127:0] key,
                          output logic [127:0] res, output int lat);
        @(negedge clk);
        work = 1'b1;
        decrypt = dec;
        @(posedge clk);
        for (int w = 0; w < 4; w++) begin
            @(negedge clk);
            blk_w = blk[127 - 32*w -: 32];
            key_w = key[127 - 32*w -: 32];
            @(posedge clk);
        end
        lat = 0;
        while (lat < 200) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (done) break;
        end
        res = result;
    endtask

    task automatic end_op(input logic [127:0] res, input string tag);
        @(negedge clk);
        chk(done == 1'b0, {tag, " R6 done pulse width"}, 128'(done), 128'd0);
        repeat (3) @(negedge clk);
        chk(result == res, {tag, " R6 held while work high"}, result, res);
        work = 1'b0;
        repeat (2) @(negedge clk);
        chk(result == res && !done, {tag, " R6 held after work low"}, result, res);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [127:0] res, res2, pt, key, ct, pt2, key2, ct2;
        int lat;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        // R1 reset state
        chk(done == 1'b0 && kerr == 1'b0, "R1 flags at reset", {126'd0, done, kerr}, 128'd0);
        chk(result == '0, "R1 result at reset", result, 128'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R7 decrypt before any key set
        work = 1'b1;
        decrypt = 1'b1;
        @(negedge clk);
        chk(kerr == 1'b1, "R7 error flag after request", 128'(kerr), 128'd1);
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            chk(kerr && !done && result == '0, "R7 rejected request idle", result, 128'd0);
        end
        work = 1'b0;
        @(negedge clk);
        chk(kerr == 1'b0, "R7 error flag clears", 128'(kerr), 128'd0);

        // R2 R3 known vector encryption
        run_op(1'b0, KV_PT, KV_KEY, res, lat);
        chk(res == KV_CT, "R2 R3 known vector ciphertext", res, KV_CT);
        chk(lat == exp_lat(1'b0), "R3 encrypt latency", 128'(lat), 128'(exp_lat(1'b0)));
        end_op(res, "R3");

        // R4 R5 decryption of known vector, key port driven with junk
        run_op(1'b1, KV_CT, rnd128(), res, lat);
        chk(res == KV_PT, "R4 known vector decrypt", res, KV_PT);
        chk(lat == exp_lat(1'b1), "R4 decrypt latency", 128'(lat), 128'(exp_lat(1'b1)));
        end_op(res, "R4");
        run_op(1'b1, KV_CT, ~KV_KEY, res, lat);
        chk(res == KV_PT, "R5 key words ignored in decrypt", res, KV_PT);
        end_op(res, "R5");

        // R8 abort mid encryption
        @(negedge clk);
        work = 1'b1;
        decrypt = 1'b0;
        @(posedge clk);
        for (int w = 0; w < 4; w++) begin
            @(negedge clk);
            blk_w = $urandom;
            key_w = $urandom;
            @(posedge clk);
        end
        repeat (21) @(negedge clk);
        work = 1'b0;
        for (int c = 0; c < 80; c++) begin
            @(negedge clk);
            if (done) chk(1'b0, "R8 no done after abort", 128'(done), 128'd0);
        end
        chk(done == 1'b0, "R8 idle after abort", 128'(done), 128'd0);
        work = 1'b1;
        decrypt = 1'b1;
        @(negedge clk);
        chk(kerr == 1'b1, "R8 aborted encryption leaves no keys", 128'(kerr), 128'd1);
        work = 1'b0;
        repeat (2) @(negedge clk);

        // random round trips
        for (int it = 0; it < 10; it++) begin
            pt  = rnd128();
            key = rnd128();
            run_op(1'b0, pt, key, ct, lat);
            chk(lat == exp_lat(1'b0), "R3 encrypt latency random", 128'(lat), 128'(exp_lat(1'b0)));
            end_op(ct, "R6");
            run_op(1'b0, pt, key, res2, lat);
            chk(res2 == ct, "R2 repeat encryption matches", res2, ct);
            end_op(res2, "R6");
            run_op(1'b1, ct, rnd128(), res, lat);
            chk(res == pt, "R4 random round trip", res, pt);
            chk(lat == exp_lat(1'b1), "R4 decrypt latency random", 128'(lat), 128'(exp_lat(1'b1)));
            end_op(res, "R4");
        end

        // R9 latest encryption supplies the keys
        pt   = rnd128();
        key  = rnd128();
        pt2  = rnd128();
        key2 = rnd128();
        run_op(1'b0, pt, key, ct, lat);
        end_op(ct, "R9");
        run_op(1'b0, pt2, key2, ct2, lat);
        end_op(ct2, "R9");
        run_op(1'b1, ct2, key, res, lat);
        chk(res == pt2, "R9 decrypt uses latest key set", res, pt2);
        end_op(res, "R9");

        // R10 constant sequence exercised again by the standard vector
        run_op(1'b0, KV_PT, KV_KEY, res, lat);
        chk(res == KV_CT, "R10 constants after reuse", res, KV_CT);
        end_op(res, "R10");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule